// File: doc/BRIEF.md
# Nibble-Chained 8-bit Add/Subtract Unit

The block computes 8-bit add, add-with-carry, subtract, subtract-with-borrow and negate on a 4-bit arithmetic core. Each operation takes two passes through the core. The low nibble is processed first. Its raw carry out is held in a register and then fed into the high pass as that pass's carry-in. Subtraction inverts the second operand and uses a carry-in of 1, so the core itself only ever adds.

A one-cycle `start_i` pulse launches an operation. One cycle later `done_o` pulses, and at that point the result and the four flags (carry, signed overflow, negative, zero) are updated. The carry flag is held in a register and is the carry source for the chained operations. The parameter `BORROW_INV` chooses how that flag reads after subtract-type operations: either "1 = no borrow" (raw carry) or "1 = borrow" (inverted carry).

Top module: `alu8_seq`

## Requirements
- R1: After reset, `result_o` is 0x00, all four flags are 0 and `done_o` is 0.
- R2: A start seen while idle produces a single-cycle `done_o` pulse two clock edges later. A start seen while a pass is in flight is ignored, and it causes no second done pulse.
- R3: `op_i` = 0 (add) gives a+b mod 256 with carry-in 0. The carry flag is the carry out of bit 7, which includes a carry that moves from the low nibble into the high nibble. Codes 5, 6 and 7 behave the same as code 0.
- R4: `op_i` = 1 (add with carry) gives a+b+C, where C is the carry flag stored by the previous operation.
- R5: `op_i` = 2 (subtract) gives a-b mod 256, computed as a + ~b + 1. With `BORROW_INV`=0 the carry flag is the raw carry out, so 1 means no borrow.
- R6: `op_i` = 3 (subtract with borrow) computes a + ~b + k. Here k is the stored carry flag when `BORROW_INV`=0, and the inverse of the stored carry flag when `BORROW_INV`=1.
- R7: `op_i` = 4 (negate) gives 0 - a. Negating 0x80 returns 0x80 with overflow set. Negating 0x00 returns 0x00 with overflow clear.
- R8: The overflow flag is set exactly when the 8-bit signed result is out of range. This equals the XOR of the carry into bit 7 and the carry out of bit 7.
- R9: The negative flag equals result bit 7. The zero flag is set only when both nibbles of the result are zero.
- R10: With `BORROW_INV`=1, the carry flag after subtract, subtract-with-borrow and negate is the inverse of the raw carry out, so 1 means borrow. After add operations it stays the raw carry out.
- R11: `result_o` and the flags change only on the edge that raises `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse, accepted when idle |
| op_i | input | 3 | Operation: 0 add, 1 adc, 2 sub, 3 sbb, 4 neg, 5-7 add |
| a_i | input | 8 | First operand (negate source) |
| b_i | input | 8 | Second operand |
| result_o | output | 8 | Result |
| c_o | output | 1 | Carry flag (polarity set by BORROW_INV) |
| v_o | output | 1 | Signed overflow flag |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench runs two instances, one for each carry polarity, and targets the carry that crosses the nibble boundary. For example, 0x0F+0x01 and 0xFF+0x01 would come out wrong by 0x10 if the low-pass carry were dropped. Chained add-with-carry and subtract-with-borrow are run after operations that leave the carry flag set and after operations that leave it clear. A design that forgot to re-invert the borrow flag in inverted mode would be off by one on those chained subtracts. Negate of 0x80 and of 0x00 checks the overflow corner. A start pulse sent while busy checks that a sequencer which re-accepts mid-flight would be caught producing an extra done pulse or a corrupted result.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_NEG = 3'd4
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HI   = 1'b1
  } st_e;
endpackage

// File: rtl/alu8_op_dec.sv
module alu8_op_dec
  import alu8_pkg::*;
#(
  parameter bit BORROW_INV = 1'b0
) (
  input  logic [2:0] op_i,
  input  logic       c_flag_i,
  output logic       neg_sel_o,  // first operand forced to zero, second = a
  output logic       inv_b_o,
  output logic       cin_o,
  output logic       flip_c_o    // store inverted carry
);
  always_comb begin
    neg_sel_o = 1'b0;
    inv_b_o   = 1'b0;
    cin_o     = 1'b0;
    case (op_i)
      OP_ADC: cin_o = c_flag_i;
      OP_SUB: begin inv_b_o = 1'b1; cin_o = 1'b1; end
      OP_SBB: begin inv_b_o = 1'b1; cin_o = BORROW_INV ? ~c_flag_i : c_flag_i; end
      OP_NEG: begin neg_sel_o = 1'b1; inv_b_o = 1'b1; cin_o = 1'b1; end
      default: ;
    endcase
    flip_c_o = BORROW_INV & inv_b_o;
  end
endmodule

// File: rtl/alu8_nib.sv
module alu8_nib #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o,
  output logic         zero_o
);
  logic [W-1:0] bb;
  logic [W-1:0] low;
  logic         c_msb;
  logic         top;

  always_comb begin
    bb = inv_b_i ? ~b_i : b_i;
    {c_msb, low[W-2:0]} = {1'b0, a_i[W-2:0]} + {1'b0, bb[W-2:0]} + {{(W-1){1'b0}}, cin_i};
    {cout_o, top} = {1'b0, a_i[W-1]} + {1'b0, bb[W-1]} + {1'b0, c_msb};
    low[W-1] = top;
    sum_o    = low;
    ovf_o    = c_msb ^ cout_o;
    zero_o   = (low == '0);
  end
endmodule

// File: rtl/alu8_seq.sv
module alu8_seq
  import alu8_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter bit BORROW_INV = 1'b0,
  localparam int DATA_W    = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              c_o,
  output logic              v_o,
  output logic              n_o,
  output logic              z_o,
  output logic              done_o
);
  st_e              st_q;
  logic             neg_sel, inv_b, cin, flip_c;
  logic [NIB_W-1:0] xa_lo, xb_lo, sum_lo, sum_hi;
  logic             cout_lo, ovf_lo, zero_lo, cout_hi, ovf_hi, zero_hi;
  logic [NIB_W-1:0] a_hi_q, b_hi_q, sum_lo_q;
  logic             inv_q, flip_q, c_lo_q, zero_lo_q;
  logic [2:0]       op_q;
  logic             accept;

  assign accept = start_i && (st_q == ST_IDLE);

  alu8_op_dec #(.BORROW_INV(BORROW_INV)) u_dec (
    .op_i     (op_i),
    .c_flag_i (c_o),
    .neg_sel_o(neg_sel),
    .inv_b_o  (inv_b),
    .cin_o    (cin),
    .flip_c_o (flip_c)
  );

  assign xa_lo = neg_sel ? '0 : a_i[NIB_W-1:0];
  assign xb_lo = neg_sel ? a_i[NIB_W-1:0] : b_i[NIB_W-1:0];

  alu8_nib #(.W(NIB_W)) u_lo (
    .a_i(xa_lo), .b_i(xb_lo), .inv_b_i(inv_b), .cin_i(cin),
    .sum_o(sum_lo), .cout_o(cout_lo), .ovf_o(ovf_lo), .zero_o(zero_lo)
  );

  // high pass sees latched operands and the raw low carry
  alu8_nib #(.W(NIB_W)) u_hi (
    .a_i(a_hi_q), .b_i(b_hi_q), .inv_b_i(inv_q), .cin_i(c_lo_q),
    .sum_o(sum_hi), .cout_o(cout_hi), .ovf_o(ovf_hi), .zero_o(zero_hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      a_hi_q    <= '0;
      b_hi_q    <= '0;
      sum_lo_q  <= '0;
      inv_q     <= 1'b0;
      flip_q    <= 1'b0;
      c_lo_q    <= 1'b0;
      zero_lo_q <= 1'b0;
      op_q      <= '0;
      result_o  <= '0;
      c_o       <= 1'b0;
      v_o       <= 1'b0;
      n_o       <= 1'b0;
      z_o       <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        st_q      <= ST_HI;
        a_hi_q    <= neg_sel ? '0 : a_i[DATA_W-1:NIB_W];
        b_hi_q    <= neg_sel ? a_i[DATA_W-1:NIB_W] : b_i[DATA_W-1:NIB_W];
        sum_lo_q  <= sum_lo;
        inv_q     <= inv_b;
        flip_q    <= flip_c;
        c_lo_q    <= cout_lo;
        zero_lo_q <= zero_lo;
        op_q      <= op_i;
      end else if (st_q == ST_HI) begin
        st_q     <= ST_IDLE;
        result_o <= {sum_hi, sum_lo_q};
        c_o      <= cout_hi ^ flip_q;
        v_o      <= ovf_hi;
        n_o      <= sum_hi[NIB_W-1];
        z_o      <= zero_hi & zero_lo_q;
        done_o   <= 1'b1;
      end
    end
  end

  // R2
  done_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ##1 done_o);
  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  add_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_ADD) |->
      (v_o == ((a_hi_q[NIB_W-1] == b_hi_q[NIB_W-1]) &&
               (result_o[DATA_W-1] != a_hi_q[NIB_W-1]))));
  // R9
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (z_o == (result_o == '0)));
  // R11
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(c_o) && $stable(v_o)));
  // lint guard on unused low-pass overflow
  lo_ovf_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(ovf_lo));
endmodule

// File: tb/alu8_seq_tb.sv
module alu8_seq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] op_i = 3'd0;
  logic [7:0] a_i = 8'h00, b_i = 8'h00;
  logic [7:0] res0, res1;
  logic       c0, v0, n0, z0, d0, c1, v1, n1, z1, d1;
  int         n_chk = 0, n_fail = 0;
  logic       mc0 = 1'b0, mc1 = 1'b0;  // model carry flags

  always #4 clk_i = ~clk_i;

  alu8_seq #(.BORROW_INV(1'b0)) u_dut (
    .clk_i, .rst_ni, .start_i, .op_i, .a_i, .b_i,
    .result_o(res0), .c_o(c0), .v_o(v0), .n_o(n0), .z_o(z0), .done_o(d0));
  alu8_seq #(.BORROW_INV(1'b1)) u_dut_b (
    .clk_i, .rst_ni, .start_i, .op_i, .a_i, .b_i,
    .result_o(res1), .c_o(c1), .v_o(v1), .n_o(n1), .z_o(z1), .done_o(d1));

  initial begin
    repeat (5000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // returns {c, v, n, z, res}
  function automatic logic [11:0] model(logic [2:0] op, logic [7:0] a, logic [7:0] b,
                                        logic cf, logic binv);
    logic [7:0] x, y;
    logic [8:0] full;
    logic cin, sub, craw, v;
    sub = (op == 3'd2) || (op == 3'd3) || (op == 3'd4);
    x = (op == 3'd4) ? 8'h00 : a;
    y = (op == 3'd4) ? a : b;
    if (sub) y = ~y;
    case (op)
      3'd1: cin = cf;
      3'd2, 3'd4: cin = 1'b1;
      3'd3: cin = binv ? ~cf : cf;
      default: cin = 1'b0;
    endcase
    full = {1'b0, x} + {1'b0, y} + {8'h00, cin};
    craw = full[8];
    v = (x[7] == y[7]) && (full[7] != x[7]);
    return {(sub && binv) ? ~craw : craw, v, full[7], full[7:0] == 8'h00, full[7:0]};
  endfunction

  task automatic run_op(string req, logic [2:0] op, logic [7:0] a, logic [7:0] b);
    logic [11:0] e0, e1;
    e0 = model(op, a, b, mc0, 1'b0);
    e1 = model(op, a, b, mc1, 1'b1);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    check({req, " R2 not done yet"}, {31'd0, d0}, 32'd0);
    @(posedge clk_i);
    @(negedge clk_i);
    check({req, " R2 done"}, {30'd0, d0, d1}, 32'd3);
    check({req, " result"}, {16'd0, res0, res1}, {16'd0, e0[7:0], e1[7:0]});
    check({req, " flags R8 R9"}, {24'd0, c0, v0, n0, z0, c1, v1, n1, z1},
          {24'd0, e0[11:8], e1[11:8]});
    mc0 = e0[11]; mc1 = e1[11];
  endtask

  task automatic t_reset();
    check("R1 result", {24'd0, res0}, 32'd0);
    check("R1 flags", {27'd0, c0, v0, n0, z0, d0}, 32'd0);
  endtask

  task automatic t_add();
    run_op("R3 nibble carry", 3'd0, 8'h0F, 8'h01);
    run_op("R3 wrap zero", 3'd0, 8'hFF, 8'h01);
    run_op("R8 pos overflow", 3'd0, 8'h7F, 8'h01);
    run_op("R8 neg overflow", 3'd0, 8'h80, 8'hFF);
    run_op("R3 alias code", 3'd6, 8'h38, 8'h49);
  endtask

  task automatic t_adc();
    run_op("R3 set carry", 3'd0, 8'hF0, 8'h20);
    run_op("R4 adc carry1", 3'd1, 8'h10, 8'h0F);
    run_op("R4 adc carry0", 3'd1, 8'h10, 8'h0F);
  endtask

  task automatic t_sub();
    run_op("R5 nibble borrow", 3'd2, 8'h10, 8'h01);
    run_op("R5 R10 underflow", 3'd2, 8'h00, 8'h01);
    run_op("R6 sbb after borrow", 3'd3, 8'h50, 8'h20);
    run_op("R8 sub overflow", 3'd2, 8'h80, 8'h01);
    run_op("R6 sbb no borrow", 3'd3, 8'h50, 8'h20);
    run_op("R10 equal", 3'd2, 8'h3C, 8'h3C);
  endtask

  task automatic t_neg();
    run_op("R7 neg 80", 3'd4, 8'h80, 8'h00);
    run_op("R7 neg 00", 3'd4, 8'h00, 8'h55);
    run_op("R7 neg 01", 3'd4, 8'h01, 8'h00);
  endtask

  task automatic t_busy();
    logic [11:0] e0;
    e0 = model(3'd0, 8'h01, 8'h01, mc0, 1'b0);
    @(negedge clk_i);
    start_i = 1'b1; op_i = 3'd0; a_i = 8'h01; b_i = 8'h01;
    @(posedge clk_i);
    @(negedge clk_i);
    op_i = 3'd2; a_i = 8'h55; b_i = 8'h11;  // start held during busy cycle
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    check("R2 busy done", {31'd0, d0}, 32'd1);
    check("R2 busy result", {24'd0, res0}, {24'd0, e0[7:0]});
    mc0 = e0[11];
    mc1 = e0[11];
    @(negedge clk_i);
    check("R2 no extra done", {31'd0, d0}, 32'd0);
    @(negedge clk_i);
    check("R11 held result", {23'd0, d0, res0}, {24'd0, e0[7:0]});
  endtask

  initial begin
    #1;
    t_reset();
    #20 rst_ni = 1'b1;
    t_add();
    t_adc();
    t_sub();
    t_neg();
    t_busy();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule